// File: doc/BRIEF.md
# Nested-Priority Interrupt Controller Bank

This block is one bank of an interrupt controller with eight request inputs. Input 0 has the highest priority. Request lines are sampled into a request register on every clock. A mask register hides selected inputs. An in-service register records which levels the processor is handling, and a level can interrupt only the levels below it. The processor takes an interrupt with a two-cycle acknowledge. It can also fetch the winning level with a poll read and never use the acknowledge.

One input can be marked as the link to a slave controller. In the regular nested mode, a slave whose level is in service is blocked until that level is released. In the special nested mode, the slave's level stays visible, so a higher-priority request forwarded by the slave can interrupt again. During the first acknowledge cycle, the bank drives the slave address onto the acknowledge data bus. A small register bus gives access to the mask, the vector base, the cascade configuration and a command register. Through the command register software issues end-of-interrupt, arms a poll, and selects which status register a read returns.

Top module: `intc_bank`

## Requirements
- R1: After reset, the request, in-service and mask registers are zero. The status read selects the request register, no poll is armed, the vector base and cascade configuration are zero, `int_o` is low, and `ack_data_o` is zero.
- R2: Each clock, bit i of the request register takes `irq_i[i]`, except for the bit that an acknowledge or poll takes in that cycle, which is cleared. Address 1 writes and reads back the 8-bit mask register.
- R3: `int_o` is high exactly when some unmasked request bit has a lower index than every set in-service bit. Rule R5 adds one exception.
- R4: In regular mode (address 3 bit 4 = 0), a cascade input that is in service cannot raise `int_o`, even while its request stays high.
- R5: In special mode (address 3 bit 4 = 1, with cascade enabled), a request on the in-service cascade input raises `int_o` and can be acknowledged again.
- R6: In the first acknowledge cycle (`inta_i` high with no acknowledge pending), `ack_data_o` carries the winning level in bits 2:0 and zero above. This applies only when that level is the enabled cascade input. Otherwise `ack_data_o` is zero.
- R7: In the second acknowledge cycle, `ack_data_o` is {vector base, level}. The level is the one latched at the first cycle. That cycle sets its in-service bit and clears its request bit. If nothing was pending at the first cycle, the level is 7 and no register changes.
- R8: A command write (address 0) with bit 2 set arms a poll. The next read of address 0 returns {bit 7 = pending, bits 2:0 = level}, or zero when nothing is pending. It takes the level as an acknowledge does and disarms the poll.
- R9: A command write with bit 1 set loads bit 0 as the status select (0 = request register, 1 = in-service register). Reads of address 0 with no poll armed return the selected register.
- R10: A command write with bit 3 set clears the lowest-index set in-service bit. A bit set in the same cycle wins.
- R11: Masked inputs never raise `int_o`, never win an acknowledge and never appear in a poll result.
- R12: Address 2 holds the vector base in bits 7:3. Address 3 holds the cascade input in bits 2:0, cascade enable in bit 3 and special mode in bit 4. Both read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Level interrupt requests, bit 0 highest |
| bus_req_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while a read is requested |
| inta_i | input | 1 | Acknowledge cycle strobe, one clock per cycle |
| ack_data_o | output | 8 | Cascade address or vector during acknowledge |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the bank with its default of eight inputs, so the three-bit level field, the full mask byte and the level-7 spurious code are all in play. Level 2 is used as the cascade input, which leaves higher levels (0, 1) that preempt it and lower levels that it blocks. A long stretch of random requests, register traffic and acknowledges reaches same-cycle collisions: end-of-interrupt together with a take, and requests that change between the two acknowledge cycles.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MASK = 2'd1,
    A_VEC  = 2'd2,
    A_CFG  = 2'd3
  } reg_addr_e;

  // command word bit positions
  localparam int unsigned CTL_RS_SEL  = 0;
  localparam int unsigned CTL_RS_LOAD = 1;
  localparam int unsigned CTL_POLL    = 2;
  localparam int unsigned CTL_EOI     = 3;
endpackage

// File: rtl/intc_ffs.sv
module intc_ffs #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          valid_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  imr_i,
  input  logic [N-1:0]  isr_i,
  input  logic          sfnm_i,
  input  logic          casc_en_i,
  input  logic [LW-1:0] casc_i,
  output logic          valid_o,
  output logic [LW-1:0] lvl_o
);
  logic [N-1:0] clear_above;
  logic [N-1:0] cand;

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == 0) begin : g_top
      assign clear_above[g] = 1'b1;
    end else begin : g_rest
      assign clear_above[g] = ~|isr_i[g-1:0];
    end
    // strict nesting, except a cascade slot re-entering itself in special mode
    assign cand[g] = irr_i[g] & ~imr_i[g] & clear_above[g] &
                     (~isr_i[g] | (sfnm_i & casc_en_i & (casc_i == LW'(g))));
  end

  intc_ffs #(.N(N), .LW(LW)) u_pick (
    .vec_i  (cand),
    .valid_o(valid_o),
    .idx_o  (lvl_o)
  );
endmodule

// File: rtl/intc_ack.sv
module intc_ack #(
  parameter int unsigned N   = 8,
  parameter int unsigned LW  = $clog2(N),
  parameter int unsigned DW  = 8,
  parameter int unsigned VBW = DW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           inta_i,
  input  logic           win_valid_i,
  input  logic [LW-1:0]  win_lvl_i,
  input  logic           casc_en_i,
  input  logic [LW-1:0]  casc_i,
  input  logic [VBW-1:0] vbase_i,
  output logic [DW-1:0]  data_o,
  output logic           take_o,
  output logic [LW-1:0]  take_lvl_o
);
  logic          phase_q;
  logic          lat_valid_q;
  logic [LW-1:0] lat_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      lat_valid_q <= 1'b0;
      lat_lvl_q   <= '0;
    end else if (inta_i) begin
      if (!phase_q) begin
        phase_q     <= 1'b1;
        lat_valid_q <= win_valid_i;
        lat_lvl_q   <= win_valid_i ? win_lvl_i : LW'(N - 1);
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  assign take_o     = inta_i & phase_q & lat_valid_q;
  assign take_lvl_o = lat_lvl_q;

  always_comb begin
    data_o = '0;
    if (inta_i) begin
      if (!phase_q) begin
        if (win_valid_i && casc_en_i && (win_lvl_i == casc_i))
          data_o = {{(DW-LW){1'b0}}, win_lvl_i};
      end else begin
        data_o = {vbase_i, lat_lvl_q};
      end
    end
  end

  a_r7_second_follows_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && phase_q) |=> !phase_q);
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [N_IRQ-1:0] bus_wdata_i,
  output logic [N_IRQ-1:0] bus_rdata_o,
  input  logic             inta_i,
  output logic [N_IRQ-1:0] ack_data_o,
  output logic             int_o
);
  localparam int unsigned DW  = N_IRQ;
  localparam int unsigned LW  = $clog2(N_IRQ);
  localparam int unsigned VBW = DW - LW;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0]  irr_q, isr_q, imr_q;
  logic [VBW-1:0] vbase_q;
  logic [LW-1:0]  casc_q;
  logic           casc_en_q, sfnm_q, rs_isr_q, poll_arm_q;

  logic           win_valid;
  logic [LW-1:0]  win_lvl;
  logic           isr_any;
  logic [LW-1:0]  isr_top;
  logic           ack_take;
  logic [LW-1:0]  ack_lvl;

  logic           wr, rd, ctrl_wr, poll_rd, poll_take, eoi;
  logic [DW-1:0]  set_vec, clr_vec;
  logic [DW-1:0]  poll_byte, cfg_byte;

  intc_prio #(.N(N_IRQ), .LW(LW)) u_prio (
    .irr_i    (irr_q),
    .imr_i    (imr_q),
    .isr_i    (isr_q),
    .sfnm_i   (sfnm_q),
    .casc_en_i(casc_en_q),
    .casc_i   (casc_q),
    .valid_o  (win_valid),
    .lvl_o    (win_lvl)
  );

  intc_ffs #(.N(N_IRQ), .LW(LW)) u_isr_top (
    .vec_i  (isr_q),
    .valid_o(isr_any),
    .idx_o  (isr_top)
  );

  intc_ack #(.N(N_IRQ), .LW(LW), .DW(DW), .VBW(VBW)) u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inta_i     (inta_i),
    .win_valid_i(win_valid),
    .win_lvl_i  (win_lvl),
    .casc_en_i  (casc_en_q),
    .casc_i     (casc_q),
    .vbase_i    (vbase_q),
    .data_o     (ack_data_o),
    .take_o     (ack_take),
    .take_lvl_o (ack_lvl)
  );

  assign wr        = bus_req_i & bus_we_i;
  assign rd        = bus_req_i & ~bus_we_i;
  assign ctrl_wr   = wr & (bus_addr_i == A_CTRL);
  assign poll_rd   = rd & (bus_addr_i == A_CTRL) & poll_arm_q;
  assign poll_take = poll_rd & win_valid;
  assign eoi       = ctrl_wr & bus_wdata_i[CTL_EOI];

  assign set_vec = (poll_take ? (ONE << win_lvl) : '0) |
                   (ack_take  ? (ONE << ack_lvl) : '0);
  assign clr_vec = (eoi && isr_any) ? (ONE << isr_top) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q      <= '0;
      isr_q      <= '0;
      imr_q      <= '0;
      vbase_q    <= '0;
      casc_q     <= '0;
      casc_en_q  <= 1'b0;
      sfnm_q     <= 1'b0;
      rs_isr_q   <= 1'b0;
      poll_arm_q <= 1'b0;
    end else begin
      irr_q <= irq_i & ~set_vec;
      isr_q <= (isr_q & ~clr_vec) | set_vec;
      if (poll_rd) poll_arm_q <= 1'b0;
      if (wr) begin
        case (bus_addr_i)
          A_CTRL: begin
            if (bus_wdata_i[CTL_POLL])    poll_arm_q <= 1'b1;
            if (bus_wdata_i[CTL_RS_LOAD]) rs_isr_q   <= bus_wdata_i[CTL_RS_SEL];
          end
          A_MASK: imr_q <= bus_wdata_i;
          A_VEC:  vbase_q <= bus_wdata_i[DW-1:LW];
          default: begin
            casc_q    <= bus_wdata_i[LW-1:0];
            casc_en_q <= bus_wdata_i[LW];
            sfnm_q    <= bus_wdata_i[LW+1];
          end
        endcase
      end
    end
  end

  always_comb begin
    poll_byte         = '0;
    poll_byte[DW-1]   = win_valid;
    poll_byte[LW-1:0] = win_valid ? win_lvl : '0;
    cfg_byte          = '0;
    cfg_byte[LW-1:0]  = casc_q;
    cfg_byte[LW]      = casc_en_q;
    cfg_byte[LW+1]    = sfnm_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        A_CTRL:  bus_rdata_o = poll_arm_q ? poll_byte : (rs_isr_q ? isr_q : irr_q);
        A_MASK:  bus_rdata_o = imr_q;
        A_VEC:   bus_rdata_o = {vbase_q, {LW{1'b0}}};
        default: bus_rdata_o = cfg_byte;
      endcase
    end
  end

  assign int_o = win_valid;

  a_r3_int_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_q & ~imr_q));
  a_r4_no_reentry_regular: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid && !sfnm_q) |-> !isr_q[win_lvl]);
  a_r7_ack_marks_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> isr_q[$past(ack_lvl)]);
  a_r8_poll_marks_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && bus_rdata_o[DW-1]) |=> isr_q[$past(bus_rdata_o[LW-1:0])]);
  a_r10_eoi_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && (set_vec == '0) && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
  a_r11_masked_never_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> !imr_q[win_lvl]);
endmodule

// File: tb/sim_intc_bank.sv
module sim_intc_bank;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       req = 1'b0, we = 1'b0, inta = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, ackd;
  logic       intr;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  bit [7:0] m_irr, m_isr, m_imr;
  bit [4:0] m_vb;
  bit [2:0] m_casc, m_ll;
  bit       m_cen, m_sf, m_rs, m_poll, m_ph, m_lv;

  intc_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .inta_i(inta), .ack_data_o(ackd), .int_o(intr)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int m_win();
    int top = 8;
    for (int i = 7; i >= 0; i--) if (m_isr[i]) top = i;
    for (int i = 0; i < 8; i++)
      if (m_irr[i] && !m_imr[i] &&
          (i < top || (m_sf && m_cen && i == int'(m_casc) && i == top)))
        return i;
    return -1;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_vb = 0; m_casc = 0; m_ll = 0;
      m_cen = 0; m_sf = 0; m_rs = 0; m_poll = 0; m_ph = 0; m_lv = 0;
    end else begin
      int w;
      bit [7:0] set_v, clr_v;
      w = m_win(); set_v = 0; clr_v = 0;
      if (inta) begin
        if (!m_ph) begin
          m_ph = 1; m_lv = (w >= 0); m_ll = (w >= 0) ? 3'(w) : 3'd7;
        end else begin
          m_ph = 0;
          if (m_lv) set_v[m_ll] = 1'b1;
        end
      end
      if (req && !we && addr == 2'd0 && m_poll) begin
        if (w >= 0) set_v[w] = 1'b1;
        m_poll = 0;
      end
      if (req && we) begin
        case (addr)
          2'd0: begin
            if (wdata[3]) begin
              for (int i = 7; i >= 0; i--) if (m_isr[i]) clr_v = 8'(1) << i;
            end
            if (wdata[2]) m_poll = 1;
            if (wdata[1]) m_rs = wdata[0];
          end
          2'd1: m_imr = wdata;
          2'd2: m_vb = wdata[7:3];
          default: begin m_casc = wdata[2:0]; m_cen = wdata[3]; m_sf = wdata[4]; end
        endcase
      end
      m_isr = (m_isr & ~clr_v) | set_v;
      m_irr = irq & ~set_v;
    end
  end

  // compare against the model every cycle, a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      int w;
      w = m_win();
      chk({7'b0, intr}, {7'b0, 1'(w >= 0)}, "R3 int");
      if (req && !we) begin
        case (addr)
          2'd0: if (m_poll) chk(rdata, (w >= 0) ? (8'h80 | 8'(w)) : 8'h00, "R8 poll");
                else        chk(rdata, m_rs ? m_isr : m_irr, "R9 status");
          2'd1: chk(rdata, m_imr, "R2 mask");
          2'd2: chk(rdata, {m_vb, 3'b0}, "R12 vbase");
          default: chk(rdata, {3'b0, m_sf, m_cen, m_casc}, "R12 cfg");
        endcase
      end
      if (inta) begin
        if (!m_ph) chk(ackd, (w >= 0 && m_cen && w == int'(m_casc)) ? 8'(w) : 8'h00, "R6 ack1");
        else       chk(ackd, {m_vb, m_ll}, "R7 ack2");
      end else begin
        chk(ackd, 8'h00, "R6 idle");
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #(CLK_P/4); d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic ack_seq();
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    // R1: reset state
    repeat (2) @(negedge clk);
    req = 1; we = 0; addr = 2'd0;
    #1;
    chk(rdata, 8'h00, "R1 status");
    chk({7'b0, intr}, 8'h00, "R1 int");
    chk(ackd, 8'h00, "R1 ack");
    req = 0;
    @(negedge clk); rst_n = 1;

    wr(2'd2, 8'h40);            // vector base 8
    wr(2'd3, 8'h0A);            // cascade on input 2, regular mode

    // plain nesting
    set_irq(8'h20); idle(2);
    chk({7'b0, intr}, 8'h01, "R3 level5 raises");
    ack_seq(); idle(2);
    chk({7'b0, intr}, 8'h00, "R3 same level blocked");
    set_irq(8'h02); idle(2);
    chk({7'b0, intr}, 8'h01, "R3 higher preempts");
    ack_seq(); set_irq(8'h00); idle(2);

    // status select and EOI
    wr(2'd0, 8'h03);
    rd(2'd0, d); chk(d, 8'h22, "R9 isr view");
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk(d, 8'h20, "R10 eoi lowest");
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk(d, 8'h00, "R10 eoi last");

    // masking and poll
    wr(2'd1, 8'h10);
    set_irq(8'h10); idle(2);
    chk({7'b0, intr}, 8'h00, "R11 masked no int");
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk(d, 8'h00, "R11 masked no poll");
    set_irq(8'h30); idle(2);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk(d, 8'h85, "R8 poll level5");
    rd(2'd0, d); chk(d, 8'h20, "R8 poll took level");
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h00);
    set_irq(8'h00); idle(2);

    // cascade, regular mode
    set_irq(8'h04); idle(2);
    ack_seq(); idle(3);
    chk({7'b0, intr}, 8'h00, "R4 cascade blocked");
    // special mode
    wr(2'd3, 8'h1A); idle(1);
    chk({7'b0, intr}, 8'h01, "R5 cascade reenters");
    ack_seq();
    wr(2'd0, 8'h08); set_irq(8'h00); idle(2);
    rd(2'd0, d); chk(d, 8'h00, "R5 one eoi clears");

    // request register view
    wr(2'd0, 8'h02);
    set_irq(8'hA0); idle(2);
    rd(2'd0, d); chk(d, 8'hA0, "R2 irr follows lines");

    // spurious acknowledge
    set_irq(8'h00); idle(2);
    ack_seq(); idle(1);
    wr(2'd0, 8'h03);
    rd(2'd0, d); chk(d, 8'h00, "R7 spurious no service");

    // random traffic against the model
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 9);
      set_irq(8'($urandom));
      if (op < 2) wr(2'($urandom), 8'($urandom));
      else if (op < 4) wr(2'd0, 8'($urandom_range(0, 15)));
      else if (op < 6) rd(2'($urandom), d);
      else if (op < 8) ack_seq();
      else idle(1);
    end
    idle(2);
    finish_run();
  end
endmodule